// File: doc/BRIEF.md
# Bus Request Channel to Memory Controller Adapter

This block sits between the slave side of an in-order, uncached split-transaction bus port and a simple memory controller port. The bus side has a request channel (A), which carries an opcode, size, source ID, address, byte mask and write data, and a response channel (D), which carries an opcode, size, source ID, an error flag and read data. Each single-beat Get or PutFull request becomes exactly one controller request. The address, mask and data go straight through to the controller, and the controller's read flag is decoded from the opcode.

The controller's response side has only data and a valid strobe, and it cannot be stalled. For that reason the adapter keeps an ordered queue of every accepted request that has not yet been answered. Each queue entry holds a read/write tag, the source ID and the size. A second queue holds returned read data until the D channel takes it. Responses leave strictly in acceptance order, so a write acknowledgement never overtakes an older read. The probe channel (B) and the two upstream channels (C, E) are tied to idle.

Top module: `tlmb_bridge`

## Requirements
- R1: `a_ready` equals `mc_req_ready` while fewer than `PEND_DEPTH` requests are unanswered. Once `PEND_DEPTH` requests are unanswered, `a_ready` and `mc_req_valid` are both low.
- R2: In the cycle of an A handshake, `mc_req_valid` is high and `mc_req_addr`, `mc_req_data` and `mc_req_mask` equal `a_address`, `a_data` and `a_mask`. `mc_req_read` is 1 exactly when `a_opcode` is 4 (Get). The PutFull opcode is 0.
- R3: Every accepted request produces exactly one D response, and responses leave in the order the requests were accepted.
- R4: A PutFull is answered with `d_opcode` 0 (AccessAck), the request's source and size, and `d_denied` 0.
- R5: A Get is answered with `d_opcode` 1 (AccessAckData), the request's source and size, `d_denied` 0, and as `d_data` the controller data returned for that read.
- R6: Read data that returns while the D channel is stalled is held and never lost. While `d_valid` is high and `d_ready` is low, all D fields hold their values into the next cycle.
- R7: A write acknowledgement is not presented before the response of any earlier read that is still outstanding.
- R8: `b_valid` is always 0, and `c_ready` and `e_ready` are always 1.
- R9: During reset, `d_valid` is 0 and `a_ready` follows `mc_req_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| a_valid | input | 1 | Request valid |
| a_ready | output | 1 | Request accepted |
| a_opcode | input | 3 | 0 PutFull, 4 Get |
| a_size | input | SIZE_W | log2 of the byte count |
| a_source | input | SRC_W | Requester ID |
| a_address | input | ADDR_W | Byte address |
| a_mask | input | DATA_W/8 | Active byte lanes |
| a_data | input | DATA_W | Write data |
| d_valid | output | 1 | Response valid |
| d_ready | input | 1 | Response taken |
| d_opcode | output | 3 | 0 AccessAck, 1 AccessAckData |
| d_size | output | SIZE_W | Echoed size |
| d_source | output | SRC_W | Echoed requester ID |
| d_denied | output | 1 | Error flag, always 0 |
| d_data | output | DATA_W | Read data |
| b_valid | output | 1 | Probe channel idle |
| c_ready | output | 1 | Channel C always accepting |
| e_ready | output | 1 | Channel E always accepting |
| mc_req_valid | output | 1 | Controller request valid |
| mc_req_ready | input | 1 | Controller can accept |
| mc_req_read | output | 1 | 1 read, 0 write |
| mc_req_addr | output | ADDR_W | Controller address |
| mc_req_data | output | DATA_W | Controller write data |
| mc_req_mask | output | DATA_W/8 | Controller byte enables |
| mc_rsp_valid | input | 1 | Read data strobe |
| mc_rsp_data | input | DATA_W | Read data |

## Verification
The assertions assume that the controller raises `mc_rsp_valid` only for reads it has already accepted, and that it returns them in order. They also assume that a requester holds a request steady until `a_ready`. Under those assumptions the data queue cannot overflow, and no data can sit in it without a pending read tag. The bench's controller model answers only accepted reads, in order, after a random delay. Its requester keeps each request unchanged until the handshake, and it holds `d_ready` low for long stretches so that both queues fill.

// File: rtl/tlmb_pkg.sv
`timescale 1ns/1ps
package tlmb_pkg;
    localparam logic [2:0] OP_PUT_FULL = 3'd0;
    localparam logic [2:0] OP_GET      = 3'd4;
    localparam logic [2:0] OP_ACK      = 3'd0;
    localparam logic [2:0] OP_ACK_DATA = 3'd1;
endpackage

// File: rtl/tlmb_fifo.sv
`timescale 1ns/1ps
module tlmb_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         full,
    output logic         empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           wp;
        logic [PW-1:0]           rp;
        logic [CW-1:0]           cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic push_ok, pop_ok;

    assign full    = (st_q.cnt == CW'(DEPTH));
    assign empty   = (st_q.cnt == '0);
    assign head    = st_q.mem[st_q.rp];
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;

    always_comb begin
        st_d = st_q;
        if (push_ok) begin
            st_d.mem[st_q.wp] = push_data;
            st_d.wp = (st_q.wp == PW'(DEPTH - 1)) ? '0 : st_q.wp + PW'(1);
        end
        if (pop_ok) begin
            st_d.rp = (st_q.rp == PW'(DEPTH - 1)) ? '0 : st_q.rp + PW'(1);
        end
        st_d.cnt = st_q.cnt + CW'(push_ok) - CW'(pop_ok);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R6: a push never meets a full queue, so nothing is dropped
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
endmodule

// File: rtl/tlmb_resp_arb.sv
`timescale 1ns/1ps
module tlmb_resp_arb
    import tlmb_pkg::*;
#(
    parameter int DATA_W = 256,
    parameter int SRC_W  = 6,
    parameter int SIZE_W = 3
) (
    input  logic              tag_avail,
    input  logic              tag_is_read,
    input  logic [SRC_W-1:0]  tag_source,
    input  logic [SIZE_W-1:0] tag_size,
    input  logic              rdat_avail,
    input  logic [DATA_W-1:0] rdat,
    input  logic              d_ready,
    output logic              d_valid,
    output logic [2:0]        d_opcode,
    output logic [SIZE_W-1:0] d_size,
    output logic [SRC_W-1:0]  d_source,
    output logic              d_denied,
    output logic [DATA_W-1:0] d_data,
    output logic              tag_pop,
    output logic              rdat_pop
);
    always_comb begin
        d_valid  = tag_avail && (!tag_is_read || rdat_avail);
        d_opcode = tag_is_read ? OP_ACK_DATA : OP_ACK;
        d_size   = tag_size;
        d_source = tag_source;
        d_denied = 1'b0;
        d_data   = tag_is_read ? rdat : '0;
        tag_pop  = d_valid && d_ready;
        rdat_pop = tag_pop && tag_is_read;
    end
endmodule

// File: rtl/tlmb_bridge.sv
`timescale 1ns/1ps
module tlmb_bridge
    import tlmb_pkg::*;
#(
    parameter int ADDR_W     = 28,
    parameter int DATA_W     = 256,
    parameter int SRC_W      = 6,
    parameter int SIZE_W     = 3,
    parameter int PEND_DEPTH = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                a_valid,
    output logic                a_ready,
    input  logic [2:0]          a_opcode,
    input  logic [SIZE_W-1:0]   a_size,
    input  logic [SRC_W-1:0]    a_source,
    input  logic [ADDR_W-1:0]   a_address,
    input  logic [DATA_W/8-1:0] a_mask,
    input  logic [DATA_W-1:0]   a_data,
    output logic                d_valid,
    input  logic                d_ready,
    output logic [2:0]          d_opcode,
    output logic [SIZE_W-1:0]   d_size,
    output logic [SRC_W-1:0]    d_source,
    output logic                d_denied,
    output logic [DATA_W-1:0]   d_data,
    output logic                b_valid,
    output logic                c_ready,
    output logic                e_ready,
    output logic                mc_req_valid,
    input  logic                mc_req_ready,
    output logic                mc_req_read,
    output logic [ADDR_W-1:0]   mc_req_addr,
    output logic [DATA_W-1:0]   mc_req_data,
    output logic [DATA_W/8-1:0] mc_req_mask,
    input  logic                mc_rsp_valid,
    input  logic [DATA_W-1:0]   mc_rsp_data
);
    localparam int TAG_W = 1 + SRC_W + SIZE_W;

    typedef struct packed {
        logic              is_read;
        logic [SRC_W-1:0]  source;
        logic [SIZE_W-1:0] size;
    } tag_t;

    tag_t        tag_in, tag_head;
    logic        tag_full, tag_empty, tag_push, tag_pop;
    logic        rdat_full, rdat_empty, rdat_pop;
    logic [DATA_W-1:0] rdat_head;

    // request path: straight through, gated by room in the tag queue
    always_comb begin
        mc_req_valid = a_valid && !tag_full;
        a_ready      = mc_req_ready && !tag_full;
        mc_req_read  = (a_opcode == OP_GET);
        mc_req_addr  = a_address;
        mc_req_data  = a_data;
        mc_req_mask  = a_mask;
        tag_push     = a_valid && a_ready;
        tag_in       = '{is_read: (a_opcode == OP_GET), source: a_source, size: a_size};
        b_valid      = 1'b0;
        c_ready      = 1'b1;
        e_ready      = 1'b1;
    end

    tlmb_fifo #(.W(TAG_W), .DEPTH(PEND_DEPTH)) u_tag_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (tag_push),
        .push_data (tag_in),
        .pop       (tag_pop),
        .head      (tag_head),
        .full      (tag_full),
        .empty     (tag_empty)
    );

    tlmb_fifo #(.W(DATA_W), .DEPTH(PEND_DEPTH)) u_rdat_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (mc_rsp_valid),
        .push_data (mc_rsp_data),
        .pop       (rdat_pop),
        .head      (rdat_head),
        .full      (rdat_full),
        .empty     (rdat_empty)
    );

    tlmb_resp_arb #(.DATA_W(DATA_W), .SRC_W(SRC_W), .SIZE_W(SIZE_W)) u_arb (
        .tag_avail   (!tag_empty),
        .tag_is_read (tag_head.is_read),
        .tag_source  (tag_head.source),
        .tag_size    (tag_head.size),
        .rdat_avail  (!rdat_empty),
        .rdat        (rdat_head),
        .d_ready     (d_ready),
        .d_valid     (d_valid),
        .d_opcode    (d_opcode),
        .d_size      (d_size),
        .d_source    (d_source),
        .d_denied    (d_denied),
        .d_data      (d_data),
        .tag_pop     (tag_pop),
        .rdat_pop    (rdat_pop)
    );

    // R1: no request leaves while the pending queue is full
    a_r1_hold_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        tag_full |-> (!a_ready && !mc_req_valid));

    // R3: read data never sits in the data queue without a pending tag
    a_r3_data_has_tag: assert property (@(posedge clk) disable iff (!rst_n)
        !rdat_empty |-> !tag_empty);

    // R3: the data queue cannot be fuller than the tag queue
    a_r3_data_not_full_alone: assert property (@(posedge clk) disable iff (!rst_n)
        rdat_full |-> tag_full);

    // R6: a stalled response holds its fields
    a_r6_d_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (d_valid && !d_ready) |=> (d_valid && $stable(d_opcode) && $stable(d_source)
                                   && $stable(d_size) && $stable(d_data)));
endmodule

// File: tb/tlmb_bridge_tb.sv
`timescale 1ns/1ps
module tlmb_bridge_tb;
    localparam int DEPTH = 4;

    logic clk = 1'b0;
    logic rst_n;
    always #5 clk = ~clk;

    logic         a_valid, a_ready;
    logic [2:0]   a_opcode;
    logic [2:0]   a_size;
    logic [5:0]   a_source;
    logic [27:0]  a_address;
    logic [31:0]  a_mask;
    logic [255:0] a_data;
    logic         d_valid, d_ready, d_denied;
    logic [2:0]   d_opcode, d_size;
    logic [5:0]   d_source;
    logic [255:0] d_data;
    logic         b_valid, c_ready, e_ready;
    logic         mc_req_valid, mc_req_ready, mc_req_read;
    logic [27:0]  mc_req_addr;
    logic [255:0] mc_req_data;
    logic [31:0]  mc_req_mask;
    logic         mc_rsp_valid;
    logic [255:0] mc_rsp_data;

    tlmb_bridge #(.PEND_DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .a_valid(a_valid), .a_ready(a_ready), .a_opcode(a_opcode), .a_size(a_size),
        .a_source(a_source), .a_address(a_address), .a_mask(a_mask), .a_data(a_data),
        .d_valid(d_valid), .d_ready(d_ready), .d_opcode(d_opcode), .d_size(d_size),
        .d_source(d_source), .d_denied(d_denied), .d_data(d_data),
        .b_valid(b_valid), .c_ready(c_ready), .e_ready(e_ready),
        .mc_req_valid(mc_req_valid), .mc_req_ready(mc_req_ready), .mc_req_read(mc_req_read),
        .mc_req_addr(mc_req_addr), .mc_req_data(mc_req_data), .mc_req_mask(mc_req_mask),
        .mc_rsp_valid(mc_rsp_valid), .mc_rsp_data(mc_rsp_data)
    );

    typedef struct packed {
        logic [2:0]   op;
        logic [5:0]   src;
        logic [2:0]   sz;
        logic [255:0] data;
    } exp_t;

    typedef struct packed {
        int           t;
        logic [255:0] data;
    } rd_t;

    exp_t expq[$];
    rd_t  rdq[$];
    int   errors = 0;
    int   checks = 0;
    int   cyc = 0;
    int   rd_n = 0;
    bit   last_hs = 0;
    bit   stall_d = 0;
    bit   prev_stall = 0;
    logic [2:0]   p_op, p_sz;
    logic [5:0]   p_src;
    logic [255:0] p_data;

    function automatic logic [255:0] pat(int n);
        logic [31:0] w;
        w = 32'hC0DE_0000 ^ 32'(n);
        return {8{w}};
    endfunction

    task automatic chk(bit ok, string req, string what, logic [255:0] act, logic [255:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step(bit allow_new);
        exp_t e;
        @(negedge clk);
        cyc++;
        if (rdq.size() > 0 && rdq[0].t <= cyc) begin
            mc_rsp_valid = 1'b1;
            mc_rsp_data  = rdq[0].data;
            void'(rdq.pop_front());
        end else begin
            mc_rsp_valid = 1'b0;
            mc_rsp_data  = '0;
        end
        mc_req_ready = ($urandom % 10) < 8;
        d_ready = stall_d ? 1'b0 : (($urandom % 10) < 7);
        if (!a_valid || last_hs) begin
            if (allow_new && ($urandom % 10) < 7) begin
                a_valid   = 1'b1;
                a_opcode  = ($urandom % 2) ? 3'd4 : 3'd0;
                a_size    = 3'($urandom % 6);
                a_source  = 6'($urandom);
                a_address = 28'($urandom);
                a_mask    = $urandom;
                a_data    = {8{$urandom}};
            end else begin
                a_valid = 1'b0;
            end
        end
        #1;
        chk(a_ready == (mc_req_ready && expq.size() < DEPTH), "R1", "a_ready",
            256'(a_ready), 256'(mc_req_ready && expq.size() < DEPTH));
        chk(!b_valid && c_ready && e_ready, "R8", "tie-offs",
            256'({b_valid, c_ready, e_ready}), 256'(3'b011));
        if (prev_stall) begin
            chk(d_valid && d_opcode == p_op && d_source == p_src && d_size == p_sz
                && d_data == p_data, "R6", "stalled D fields", d_data, p_data);
        end
        prev_stall = d_valid && !d_ready;
        p_op = d_opcode; p_src = d_source; p_sz = d_size; p_data = d_data;
        if (d_valid && d_ready) begin
            if (expq.size() == 0) begin
                chk(1'b0, "R3", "unexpected response", 256'(d_source), '0);
            end else begin
                e = expq.pop_front();
                if (e.op == 3'd0) begin
                    chk(d_opcode == 3'd0 && d_source == e.src && d_size == e.sz && !d_denied,
                        "R4 R7", "write ack", {d_opcode, d_source, d_size, d_denied},
                        {e.op, e.src, e.sz, 1'b0});
                end else begin
                    chk(d_opcode == 3'd1 && d_source == e.src && d_size == e.sz && !d_denied,
                        "R5 R3", "read resp fields", {d_opcode, d_source, d_size, d_denied},
                        {e.op, e.src, e.sz, 1'b0});
                    chk(d_data == e.data, "R5 R6", "read data", d_data, e.data);
                end
            end
        end
        last_hs = a_valid && a_ready;
        if (last_hs) begin
            chk(mc_req_valid && mc_req_addr == a_address && mc_req_data == a_data
                && mc_req_mask == a_mask && mc_req_read == (a_opcode == 3'd4),
                "R2", "controller request", {mc_req_read, mc_req_addr}, {a_opcode == 3'd4, a_address});
            e.op  = (a_opcode == 3'd4) ? 3'd1 : 3'd0;
            e.src = a_source;
            e.sz  = a_size;
            e.data = (a_opcode == 3'd4) ? pat(rd_n) : '0;
            expq.push_back(e);
            if (a_opcode == 3'd4) begin
                rdq.push_back('{t: cyc + 1 + int'($urandom % 5), data: pat(rd_n)});
                rd_n++;
            end
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        a_valid = 0; a_opcode = 0; a_size = 0; a_source = 0; a_address = 0;
        a_mask = 0; a_data = 0; d_ready = 0; mc_req_ready = 0;
        mc_rsp_valid = 0; mc_rsp_data = 0;
        repeat (3) @(negedge clk);
        #1;
        chk(!d_valid && !a_ready, "R9", "reset, controller busy",
            256'({d_valid, a_ready}), 256'(0));
        @(negedge clk);
        mc_req_ready = 1'b1;
        #1;
        chk(!d_valid && a_ready, "R9", "reset, controller ready",
            256'({d_valid, a_ready}), 256'(1));
        chk(!b_valid && c_ready && e_ready, "R8", "tie-offs in reset",
            256'({b_valid, c_ready, e_ready}), 256'(3'b011));
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 3000; i++) begin
            stall_d = (i < 150) || (i >= 1200 && i < 1300);
            step(1'b1);
        end
        stall_d = 1'b0;
        while (expq.size() > 0 || rdq.size() > 0) step(1'b0);
        step(1'b0);
        chk(!d_valid && expq.size() == 0, "R3", "all answered once",
            256'(d_valid), 256'(0));
        finish_run();
    end
endmodule